// File: doc/BRIEF.md
# Auxiliary PWM generator with buffered reload

A single-channel pulse-width generator built around a free-running time-stamp counter. Software programs a period and a compare count through a small write-only bus with combinational read-back. Each count exists in two copies. The active copy drives the waveform now. The buffered copy is loaded into the active copy only at the next period boundary, so a running waveform can be retuned without a truncated or stretched pulse.

A 16-bit control word holds four things:
- the waveform enable;
- the output sense, which chooses whether the compare count sets the high time or the low time;
- the counter run/stop bit;
- a two-bit sync-selection field, which is stored and read back only.

When the waveform enable is off, the pin is driven low whatever the output sense.

Top module: `aux_pwm`

## Requirements
- R1: After reset, every register reads 0, the counter is stopped and `pwm_out` is low.
- R2: Byte offsets select the registers. Active period is at 0x08, active compare at 0x0C, buffered period at 0x10 and buffered compare at 0x14, each 32 bits wide. The control word is at 0x2A; its write takes `wdata[15:0]`, and it reads back as 16 bits with the upper bits zero. Every other offset reads 0, and a write to it changes nothing.
- R3: A write to the active period or active compare register takes effect in the next cycle.
- R4: The buffered period and buffered compare registers read back their last written value. Once either of them has been written, both are copied into the active registers on the next period boundary. Until that boundary the active registers keep their contents. A boundary with no buffered write since the last copy changes nothing. If a bus write to an active register falls in the same cycle as a boundary copy, the bus write wins for that register.
- R5: Control bit 4 set makes the counter advance by one each clock. A cycle in which the count is at or above the active period is a period boundary, and on that cycle the count returns to 0. With bit 4 clear, the count holds its value.
- R6: With control bit 9 clear, `pwm_out` is 0 regardless of control bit 10.
- R7: With bit 9 set and bit 10 clear, `pwm_out` is high while the count is below the active compare value and low otherwise. Setting bit 10 inverts this.
- R8: A compare value at or above the active period gives a constant active level, which is high when bit 10 is clear and low when it is set.
- R9: A write of 0 to either period register stores 1.
- R10: Control bits 7:6 are stored and read back, and they have no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 6 | Byte offset of the register to write or read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data of the register at `addr` |
| pwm_out | output | 1 | Waveform output |

## Verification
The hardest situations to reach from the ports are coincidences with the period boundary. One is a buffered write landing exactly on the boundary cycle. Another is an active period written below the current count, which makes the very next cycle a boundary. A third is a bus write to an active register colliding with a boundary copy. The random phase keeps periods below about 25 counts and writes in roughly one cycle out of six, so these coincidences occur many times. A cycle-level model built from the requirements is compared against `pwm_out` on every cycle and against the read data at random offsets.

// File: rtl/aux_pwm.sv
module aux_pwm #(
  parameter int CW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          pwm_out
);
  localparam logic [AW-1:0] OFS_PER  = AW'(8'h08);
  localparam logic [AW-1:0] OFS_CMP  = AW'(8'h0C);
  localparam logic [AW-1:0] OFS_SPER = AW'(8'h10);
  localparam logic [AW-1:0] OFS_SCMP = AW'(8'h14);
  localparam logic [AW-1:0] OFS_CTL  = AW'(8'h2A);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] per_q, cmp_q, sper_q, scmp_q, cnt_q;
  logic [15:0]   ctl_q;
  logic          pend_q;

  wire run   = ctl_q[4];
  wire mode  = ctl_q[9];
  wire pol   = ctl_q[10];

  wire wr_per  = wr_en && (addr == OFS_PER);
  wire wr_cmp  = wr_en && (addr == OFS_CMP);
  wire wr_sper = wr_en && (addr == OFS_SPER);
  wire wr_scmp = wr_en && (addr == OFS_SCMP);
  wire wr_ctl  = wr_en && (addr == OFS_CTL);

  wire [CW-1:0] wdat_nz = (wdata == '0) ? ONE : wdata;
  wire boundary = run && (cnt_q >= per_q);
  wire xfer     = boundary && pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q  <= '0;
      cmp_q  <= '0;
      sper_q <= '0;
      scmp_q <= '0;
      cnt_q  <= '0;
      ctl_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (run) cnt_q <= boundary ? '0 : cnt_q + ONE;

      if (wr_per)    per_q <= wdat_nz;
      else if (xfer) per_q <= sper_q;

      if (wr_cmp)    cmp_q <= wdata;
      else if (xfer) cmp_q <= scmp_q;

      if (wr_sper) sper_q <= wdat_nz;
      if (wr_scmp) scmp_q <= wdata;

      if (wr_sper || wr_scmp) pend_q <= 1'b1;
      else if (xfer)          pend_q <= 1'b0;

      if (wr_ctl) ctl_q <= wdata[15:0];
    end
  end

  wire active = (cnt_q < cmp_q) || (cmp_q >= per_q);
  assign pwm_out = mode && (active ^ pol);

  always_comb begin
    case (addr)
      OFS_PER:  rdata = per_q;
      OFS_CMP:  rdata = cmp_q;
      OFS_SPER: rdata = sper_q;
      OFS_SCMP: rdata = scmp_q;
      OFS_CTL:  rdata = CW'(ctl_q);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/aux_pwm_chk.sv
module aux_pwm_chk #(
  parameter int CW = 32,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic          pwm_out,
  input logic [15:0]   ctl_q,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] per_q,
  input logic [CW-1:0] sper_q,
  input logic          pend_q
);
  localparam logic [AW-1:0] A_PER = AW'(8'h08);

  p_mode_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[9] |-> !pwm_out);

  p_stop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[4] |=> $stable(cnt_q));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[4] && cnt_q >= per_q) |=> (cnt_q == '0));

  p_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[4] && cnt_q < per_q) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  p_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[4] && cnt_q >= per_q && pend_q && !(wr_en && addr == A_PER))
      |=> (per_q == $past(sper_q)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && addr == A_PER) && !(ctl_q[4] && cnt_q >= per_q))
      |=> $stable(per_q));

  p_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PER) |=> (per_q != '0));
endmodule

bind aux_pwm aux_pwm_chk #(.CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .pwm_out(pwm_out),
  .ctl_q(ctl_q), .cnt_q(cnt_q), .per_q(per_q), .sper_q(sper_q), .pend_q(pend_q)
);

// File: tb/tb_aux_pwm.sv
`timescale 1ns/1ps
module tb_aux_pwm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  aux_pwm dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
               .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

  logic [31:0] m_per, m_cmp, m_sper, m_scmp, m_cnt;
  logic [15:0] m_ctl;
  logic        m_pend;
  logic        t_bnd, t_xf;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_per = 0; m_cmp = 0; m_sper = 0; m_scmp = 0; m_cnt = 0; m_ctl = 0; m_pend = 0;
    end else begin
      t_bnd = m_ctl[4] && (m_cnt >= m_per);
      t_xf  = t_bnd && m_pend;
      if (m_ctl[4]) m_cnt = t_bnd ? 32'd0 : m_cnt + 32'd1;
      if (t_xf) begin
        m_per  = m_sper;
        m_cmp  = m_scmp;
        m_pend = 1'b0;
      end
      if (wr_en) begin
        case (addr)
          6'h08: m_per  = (wdata == 0) ? 32'd1 : wdata;
          6'h0C: m_cmp  = wdata;
          6'h10: begin m_sper = (wdata == 0) ? 32'd1 : wdata; m_pend = 1'b1; end
          6'h14: begin m_scmp = wdata; m_pend = 1'b1; end
          6'h2A: m_ctl  = wdata[15:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic exp_pwm();
    logic act;
    act = (m_cnt < m_cmp) || (m_cmp >= m_per);
    return m_ctl[9] && (act ^ m_ctl[10]);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [5:0] a);
    case (a)
      6'h08: return m_per;
      6'h0C: return m_cmp;
      6'h10: return m_sper;
      6'h14: return m_scmp;
      6'h2A: return {16'd0, m_ctl};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    addr = a; wr_en = 1'b0; #0.5;
    chk(tag, rdata, exp);
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi;
    logic [5:0] alist [6];
    alist = '{6'h08, 6'h0C, 6'h10, 6'h14, 6'h2A, 6'h00};
    void'($urandom(32'd12345));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 5; i++) rd_chk("R1 reset readback", alist[i], 32'd0);
    chk("R1 output low", {31'd0, pwm_out}, 32'd0);

    // R9 zero period clamp
    wr(6'h08, 32'd0); rd_chk("R9 active period zero", 6'h08, 32'd1);
    wr(6'h10, 32'd0); rd_chk("R9 buffered period zero", 6'h10, 32'd1);
    // R2 R10 control readback, unmapped
    wr(6'h2A, 32'hFFFF_02D0); rd_chk("R2 R10 control readback", 6'h2A, 32'h0000_02D0);
    wr(6'h00, 32'hDEAD_BEEF); rd_chk("R2 unmapped read", 6'h00, 32'd0);
    rd_chk("R2 unmapped write ignored", 6'h0C, 32'd0);
    wr(6'h2A, 32'd0);

    // R7 waveform, period 5 => 6 cycles per period
    wr(6'h08, 32'd5); wr(6'h0C, 32'd2);
    rd_chk("R3 active compare", 6'h0C, 32'd2);
    wr(6'h2A, 32'h0210);
    count_high(12, hi); chk("R7 high-active duty", hi, 32'd4);
    wr(6'h2A, 32'h06D0);
    count_high(12, hi); chk("R7 R10 low-active duty", hi, 32'd8);
    wr(6'h2A, 32'h0210); wr(6'h0C, 32'd9);
    count_high(12, hi); chk("R8 compare above period", hi, 32'd12);
    wr(6'h0C, 32'd5);
    count_high(12, hi); chk("R8 compare equal period", hi, 32'd12);
    wr(6'h2A, 32'h0410);
    count_high(12, hi); chk("R6 mode off, low-active", hi, 32'd0);
    wr(6'h0C, 32'd2); wr(6'h2A, 32'h0200);
    count_high(12, hi); chk("R5 stopped output constant", (hi == 0 || hi == 12), 32'd1);

    // R4 buffered reload
    wr(6'h2A, 32'h0210);
    wr(6'h10, 32'd3);
    rd_chk("R4 active period before boundary", 6'h08, 32'd5);
    rd_chk("R4 buffered readback", 6'h10, 32'd3);
    repeat (8) @(negedge clk);
    rd_chk("R4 active period after boundary", 6'h08, 32'd3);
    rd_chk("R4 compare copied too", 6'h0C, 32'd0);
    wr(6'h0C, 32'd1);
    rd_chk("R3 active compare while running", 6'h0C, 32'd1);
    repeat (10) @(negedge clk);
    rd_chk("R4 no reload without buffered write", 6'h0C, 32'd1);

    // Random phase against the model
    for (int it = 0; it < 6000; it++) begin
      @(negedge clk);
      wr_en = 1'b0;
      chk("R5 R6 R7 R8 pwm_out model", {31'd0, pwm_out}, {31'd0, exp_pwm()});
      addr = alist[$urandom_range(0, 5)];
      #0.5;
      chk("R2 R4 readback model", rdata, exp_rd(addr));
      if ($urandom_range(0, 5) == 0) begin
        int k;
        k = $urandom_range(0, 5);
        addr = alist[k];
        case (k)
          0, 2: wdata = $urandom_range(0, 24);
          1, 3: wdata = $urandom_range(0, 28);
          4: wdata = {16'd0, 5'd0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 7) != 0),
                      1'b0, 2'($urandom_range(0, 3)), 1'b0, 1'($urandom_range(0, 7) != 0), 4'd0};
          default: wdata = $urandom;
        endcase
        wr_en = 1'b1;
      end
    end
    @(negedge clk); wr_en = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule